// File: doc/BRIEF.md
# GPIO Controller with Sticky Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. Each pin has its own control bits: input enable, output enable, output data, output inversion, pull-up enable and a drive-strength code. External inputs are registered on the clock together with a per-pin "externally driven" flag. The block then settles each pin's level with a fixed priority. An external driver comes first. The internal output comes next when output is enabled. The pull-up setting applies when neither drives the pin. The resolved level is presented on a per-pin output.

The level seen by software is the input enable ANDed with the resolved pin level. Four sticky pending flags per pin are built from it: level high, level low, rising edge and falling edge. Each flag class has its own enable mask. Each pin raises its own interrupt line whenever any enabled class is pending for that pin.

A sticky per-pin contention flag records any cycle in which a pin was both externally driven and output-enabled. The alternate-function enable and select words are stored and can be read back, but they have no effect on the pins. Software reaches everything through a plain 32-bit word read/write port. Read data is combinational from the address, and a write takes effect at the clock edge.

Top module: `gpio_sticky_ctrl`

## Requirements
- R1: With no external driver and output enabled, the pin level equals output data XOR output inversion. With output disabled, data and inversion have no effect.
- R2: The pin level priority is: the captured external level if the pin is externally driven, otherwise the internal output if output-enabled, otherwise the pull-up enable bit.
- R3: The sampled level is input enable AND pin level. The value register (offset 0x00) returns the sampled level registered at the previous clock edge. It is read-only, and writes to it are ignored.
- R4: The high-pending flag of a pin sets at every clock edge where the sampled level is 1. The low-pending flag sets at every edge where it is 0. Both flags hold until cleared by software.
- R5: The rise-pending flag sets at an edge where the sampled level is 1 and the registered previous sampled level is 0. The fall-pending flag sets when the sampled level is 0 and the previous level is 1.
- R6: Writing to a pending register clears exactly the flags whose written bit is 1. Bits written as 0 have no effect. When a set condition and a clear hit the same flag at the same edge, the flag stays set.
- R7: irq[i] is 1 exactly when, for pin i, any of the four pending flags is 1 while its enable bit is 1. It is combinational from those registers.
- R8: A synchronous active-high reset clears every register, the captured external inputs and the sampled-level history. While reset is held, all reads, pin_out and irq are 0.
- R9: Byte offsets: 0x00 value (read-only), 0x04 input enable, 0x08 output enable, 0x0C output data, 0x10 output inversion, 0x14 pull-up enable, 0x18 drive strength, 0x1C alternate enable, 0x20 alternate select, 0x24 high enable, 0x28 high pending, 0x2C low enable, 0x30 low pending, 0x34 rise enable, 0x38 rise pending, 0x3C fall enable, 0x40 fall pending, 0x44 contention. Bit i of each register belongs to pin i. Any other offset, and any offset with a nonzero low two bits, reads 0, and a write to it changes nothing.
- R10: The contention flag of a pin sets at any edge where the pin is externally driven (as captured) and output-enabled. It holds until a write of 1 to its bit at offset 0x44, and the set wins over a clear at the same edge.
- R11: Drive strength, alternate enable and alternate select store the written word and read it back. They have no effect on pin_out.
- R12: pin_in and pin_driven are captured at the clock edge. A change on them reaches pin_out only after the next rising edge. While a pin is undriven, its pin_in level has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NPINS | External level per pin |
| pin_driven | input | NPINS | 1 where an external driver is present |
| pin_out | output | NPINS | Resolved pin level |
| irq | output | NPINS | Per-pin interrupt line |

## Verification
The pin-level resolution is tried with a table of ten control and drive combinations on one pin. The table covers the pull-up alone, the output with and without inversion, the output disabled with data set, an external driver against the output and against the pull-up, and the input disabled. Together these rows separate each priority level and the XOR from its neighbours. The event tests walk one driven pin through a low-to-high and a high-to-low transition. They show that edge flags fire once while level flags reassert. Clears with mixed 0 and 1 bits, and a clear that collides with a live level, separate the write-1-to-clear rule from set-wins. Contention, stored-only registers, unmapped and misaligned offsets, and the one-cycle capture delay get directed checks.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int SEL_W  = 5;
    localparam int NSLOT  = 2 ** SEL_W;

    typedef enum logic [SEL_W-1:0] {
        REG_VAL     = 5'd0,
        REG_IEN     = 5'd1,
        REG_OEN     = 5'd2,
        REG_ODAT    = 5'd3,
        REG_OINV    = 5'd4,
        REG_PULL    = 5'd5,
        REG_DRV     = 5'd6,
        REG_ALTEN   = 5'd7,
        REG_ALTSEL  = 5'd8,
        REG_HI_EN   = 5'd9,
        REG_HI_PD   = 5'd10,
        REG_LO_EN   = 5'd11,
        REG_LO_PD   = 5'd12,
        REG_RISE_EN = 5'd13,
        REG_RISE_PD = 5'd14,
        REG_FALL_EN = 5'd15,
        REG_FALL_PD = 5'd16,
        REG_CONFL   = 5'd17,
        REG_NONE    = 5'd31
    } reg_sel_e;

    localparam logic [ADDR_W-3:0] LAST_WORD = (ADDR_W-2)'(REG_CONFL);

    typedef struct packed {
        logic in_en;
        logic out_en;
        logic out_dat;
        logic out_inv;
        logic pull_en;
    } pin_cfg_t;

    typedef struct packed {
        logic hi;
        logic lo;
        logic rise;
        logic fall;
    } pend_t;

    // Word decode; misaligned or out-of-map addresses select nothing.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-3:0] word;
        word = a[ADDR_W-1:2];
        if (a[1:0] != 2'b00 || word > LAST_WORD) return REG_NONE;
        return reg_sel_e'(word[SEL_W-1:0]);
    endfunction

    function automatic logic is_ctl_slot(input reg_sel_e s);
        return s inside {REG_IEN, REG_OEN, REG_ODAT, REG_OINV, REG_PULL,
                         REG_DRV, REG_ALTEN, REG_ALTSEL, REG_HI_EN,
                         REG_LO_EN, REG_RISE_EN, REG_FALL_EN};
    endfunction

    // Priority: external driver, then internal output, then pull-up.
    function automatic logic resolve_pin(input pin_cfg_t c, input logic drv,
                                         input logic ext);
        logic oval;
        oval = c.out_en & (c.out_dat ^ c.out_inv);
        if (drv)      return ext;
        if (c.out_en) return oval;
        return c.pull_en;
    endfunction

    function automatic logic sticky_next(input logic cur, input logic set,
                                         input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  reg_sel_e                     sel,
    input  logic [NPINS-1:0]             wdata,
    output logic [NSLOT-1:0][NPINS-1:0]  ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en && is_ctl_slot(sel)) begin
            ctl_q[sel] <= wdata;
        end
    end

    // R9 / R3: writes outside the control words leave every control word alone
    p_unmapped_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_ctl_slot(sel)) |=> $stable(ctl_q))
        else $error("write to non-control slot changed control state");

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] ext_val,
    input  logic [NPINS-1:0] ext_drv,
    input  logic [NPINS-1:0] ien,
    input  logic [NPINS-1:0] oen,
    input  logic [NPINS-1:0] odat,
    input  logic [NPINS-1:0] oinv,
    input  logic [NPINS-1:0] pull,
    output logic [NPINS-1:0] drv_q,
    output logic [NPINS-1:0] pin_val,
    output logic [NPINS-1:0] samp
);

    logic [NPINS-1:0] ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '0;
            ext_q <= '0;
        end else begin
            drv_q <= ext_drv;
            ext_q <= ext_val;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg        = '{in_en: ien[i], out_en: oen[i], out_dat: odat[i],
                              out_inv: oinv[i], pull_en: pull[i]};
        assign pin_val[i] = resolve_pin(cfg, drv_q[i], ext_q[i]);
        assign samp[i]    = cfg.in_en & pin_val[i];
    end

    // R12: the driven mask follows the port with exactly one edge of delay
    p_capture_delay_r12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> drv_q == $past(ext_drv))
        else $error("driven mask not captured one edge later");

endmodule

// File: rtl/gpio_event_track.sv
module gpio_event_track
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] samp,
    input  logic [NPINS-1:0] drv_q,
    input  logic [NPINS-1:0] oen,
    input  logic [NPINS-1:0] hi_en,
    input  logic [NPINS-1:0] lo_en,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] sval,
    output logic [NPINS-1:0] hi_pd,
    output logic [NPINS-1:0] lo_pd,
    output logic [NPINS-1:0] rise_pd,
    output logic [NPINS-1:0] fall_pd,
    output logic [NPINS-1:0] confl,
    output logic [NPINS-1:0] irq
);

    pend_t clr_cls;
    logic  clr_conf;

    assign clr_cls  = '{hi:   wr_en && sel == REG_HI_PD,
                        lo:   wr_en && sel == REG_LO_PD,
                        rise: wr_en && sel == REG_RISE_PD,
                        fall: wr_en && sel == REG_FALL_PD};
    assign clr_conf = wr_en && sel == REG_CONFL;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pend_t pend_q, pend_set, pend_clr, pend_en;
        logic  sval_q, conf_q, conf_set, conf_clr;

        assign pend_set = '{hi: samp[i], lo: ~samp[i],
                            rise: samp[i] & ~sval_q,
                            fall: ~samp[i] & sval_q};
        assign pend_clr = clr_cls & {4{wdata[i]}};
        assign pend_en  = '{hi: hi_en[i], lo: lo_en[i],
                            rise: rise_en[i], fall: fall_en[i]};
        assign conf_set = drv_q[i] & oen[i];
        assign conf_clr = clr_conf & wdata[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= '0;
                sval_q <= 1'b0;
                conf_q <= 1'b0;
            end else begin
                pend_q.hi   <= sticky_next(pend_q.hi,   pend_set.hi,   pend_clr.hi);
                pend_q.lo   <= sticky_next(pend_q.lo,   pend_set.lo,   pend_clr.lo);
                pend_q.rise <= sticky_next(pend_q.rise, pend_set.rise, pend_clr.rise);
                pend_q.fall <= sticky_next(pend_q.fall, pend_set.fall, pend_clr.fall);
                sval_q      <= samp[i];
                conf_q      <= sticky_next(conf_q, conf_set, conf_clr);
            end
        end

        assign sval[i]    = sval_q;
        assign hi_pd[i]   = pend_q.hi;
        assign lo_pd[i]   = pend_q.lo;
        assign rise_pd[i] = pend_q.rise;
        assign fall_pd[i] = pend_q.fall;
        assign confl[i]   = conf_q;
        assign irq[i]     = |(pend_q & pend_en);

        // R4: a high flag not being cleared stays set
        p_hi_sticky_r4: assert property (@(posedge clk) disable iff (rst)
            (pend_q.hi && !(clr_cls.hi && wdata[i])) |=> pend_q.hi)
            else $error("high pending dropped without a clear");
        // R4: a low sampled level always leaves the low flag set
        p_lo_level_r4: assert property (@(posedge clk) disable iff (rst)
            !samp[i] |=> pend_q.lo)
            else $error("low pending missing while level low");
        // R5: a 0->1 step of the sampled level sets rise
        p_rise_edge_r5: assert property (@(posedge clk) disable iff (rst)
            (samp[i] && !sval[i]) |=> pend_q.rise)
            else $error("rise pending missing after 0->1");
        // R5: a 1->0 step of the sampled level sets fall
        p_fall_edge_r5: assert property (@(posedge clk) disable iff (rst)
            (!samp[i] && sval[i]) |=> pend_q.fall)
            else $error("fall pending missing after 1->0");
        // R6: a clear with no competing set empties the flag
        p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
            (clr_cls.hi && wdata[i] && !samp[i]) |=> !pend_q.hi)
            else $error("high pending survived a write-1 clear");
        // R6: set wins over a simultaneous clear
        p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
            (clr_cls.hi && wdata[i] && samp[i]) |=> pend_q.hi)
            else $error("clear beat a live high level");
        // R10: contention is recorded
        p_contention_r10: assert property (@(posedge clk) disable iff (rst)
            (drv_q[i] && oen[i]) |=> confl[i])
            else $error("contention not recorded");
    end

endmodule

// File: rtl/gpio_sticky_ctrl.sv
module gpio_sticky_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  pin_driven,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  irq
);

    reg_sel_e                    sel;
    logic [NSLOT-1:0][NPINS-1:0] ctl;
    logic [NPINS-1:0]            wdata;
    logic [NPINS-1:0]            drv_q, samp;
    logic [NPINS-1:0]            sval, hi_pd, lo_pd, rise_pd, fall_pd, confl;

    assign sel   = decode_addr(bus_addr);
    assign wdata = bus_wdata[NPINS-1:0];

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (wdata),
        .ctl_q (ctl)
    );

    gpio_pin_resolve #(.NPINS(NPINS)) u_resolve (
        .clk     (clk),
        .rst     (rst),
        .ext_val (pin_in),
        .ext_drv (pin_driven),
        .ien     (ctl[REG_IEN]),
        .oen     (ctl[REG_OEN]),
        .odat    (ctl[REG_ODAT]),
        .oinv    (ctl[REG_OINV]),
        .pull    (ctl[REG_PULL]),
        .drv_q   (drv_q),
        .pin_val (pin_out),
        .samp    (samp)
    );

    gpio_event_track #(.NPINS(NPINS)) u_track (
        .clk     (clk),
        .rst     (rst),
        .samp    (samp),
        .drv_q   (drv_q),
        .oen     (ctl[REG_OEN]),
        .hi_en   (ctl[REG_HI_EN]),
        .lo_en   (ctl[REG_LO_EN]),
        .rise_en (ctl[REG_RISE_EN]),
        .fall_en (ctl[REG_FALL_EN]),
        .wr_en   (bus_wr),
        .sel     (sel),
        .wdata   (wdata),
        .sval    (sval),
        .hi_pd   (hi_pd),
        .lo_pd   (lo_pd),
        .rise_pd (rise_pd),
        .fall_pd (fall_pd),
        .confl   (confl),
        .irq     (irq)
    );

    always_comb begin
        unique case (sel)
            REG_VAL:     bus_rdata = DATA_W'(sval);
            REG_HI_PD:   bus_rdata = DATA_W'(hi_pd);
            REG_LO_PD:   bus_rdata = DATA_W'(lo_pd);
            REG_RISE_PD: bus_rdata = DATA_W'(rise_pd);
            REG_FALL_PD: bus_rdata = DATA_W'(fall_pd);
            REG_CONFL:   bus_rdata = DATA_W'(confl);
            REG_NONE:    bus_rdata = '0;
            default:     bus_rdata = DATA_W'(ctl[sel]);
        endcase
    end

    // R8: nothing visible while reset is held after the first edge
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> (irq == '0 && bus_rdata == '0 || !rst))
        else $error("outputs not quiet in reset");

endmodule

// File: tb/tb_gpio_sticky_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_sticky_ctrl;

    localparam int N = 32;

    localparam logic [7:0] A_VAL = 8'h00, A_IEN = 8'h04, A_OEN = 8'h08,
        A_ODAT = 8'h0C, A_OINV = 8'h10, A_PULL = 8'h14, A_DRV = 8'h18,
        A_ALTEN = 8'h1C, A_ALTSEL = 8'h20, A_HI_EN = 8'h24, A_HI_PD = 8'h28,
        A_LO_PD = 8'h30, A_RISE_EN = 8'h34, A_RISE_PD = 8'h38,
        A_FALL_EN = 8'h3C, A_FALL_PD = 8'h40, A_CONFL = 8'h44;

    // bits: [7] driven [6] ext level [5] oe [4] data [3] inv [2] pull [1] ie [0] expected pin
    localparam logic [7:0] VEC [10] = '{
        8'b0000_0010, 8'b0000_0111, 8'b0011_0011, 8'b0011_1110, 8'b0010_1011,
        8'b1011_0110, 8'b1100_0011, 8'b1100_0001, 8'b0001_1010, 8'b1000_0110
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] pin_in = '0, pin_driven = '0;
    logic [N-1:0] pin_out, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_sticky_ctrl #(.NPINS(N)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_driven(pin_driven), .pin_out(pin_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_ext(input int pin, input logic drv, input logic lvl);
        @(negedge clk);
        pin_driven[pin] = drv;
        pin_in[pin]     = lvl;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [N-1:0] snap;

        // R8: reset state
        repeat (2) @(posedge clk);
        rd(A_VAL, r);   chk("R8 value in reset", r, 0);
        rd(A_LO_PD, r); chk("R8 low pending in reset", r, 0);
        rd(A_CONFL, r); chk("R8 contention in reset", r, 0);
        chk("R8 pin_out in reset", pin_out, 0);
        chk("R8 irq in reset", irq, 0);
        @(negedge clk); rst = 1'b0;

        // R4: sampled level 0 everywhere -> low pending after one edge
        rd(A_LO_PD, r); chk("R4 low pending after reset", r, 32'hFFFF_FFFF);

        // R1 R2 R3: resolution table on pin 3
        foreach (VEC[k]) begin
            logic [7:0] v;
            v = VEC[k];
            set_ext(3, v[7], v[6]);
            wr(A_IEN,  32'(v[1]) << 3);
            wr(A_OEN,  32'(v[5]) << 3);
            wr(A_ODAT, 32'(v[4]) << 3);
            wr(A_OINV, 32'(v[3]) << 3);
            wr(A_PULL, 32'(v[2]) << 3);
            @(negedge clk);
            chk($sformatf("R1/R2 row %0d pin level", k), 32'(pin_out[3]), 32'(v[0]));
            repeat (2) @(posedge clk);
            rd(A_VAL, r);
            chk($sformatf("R3 row %0d value reg", k), 32'(r[3]), 32'(v[1] & v[0]));
        end

        // R4 R5 R6: edge and level flags on pin 5
        set_ext(5, 1'b1, 1'b0);
        wr(A_IEN, 32'h20);
        repeat (2) @(posedge clk);
        wr(A_RISE_PD, 32'hFFFF_FFFF);
        wr(A_FALL_PD, 32'hFFFF_FFFF);
        wr(A_HI_PD,   32'hFFFF_FFFF);
        rd(A_RISE_PD, r); chk("R6 rise cleared", r, 0);
        rd(A_HI_PD, r);   chk("R6 high cleared", r, 0);
        wr(A_LO_PD, 32'hFFFF_FFFF);
        rd(A_LO_PD, r);   chk("R6 low set wins over clear", r, 32'hFFFF_FFFF);

        set_ext(5, 1'b1, 1'b1);
        repeat (2) @(posedge clk);
        rd(A_RISE_PD, r); chk("R5 rise on 0->1", r, 32'h20);
        rd(A_FALL_PD, r); chk("R5 no fall on 0->1", r, 0);
        rd(A_HI_PD, r);   chk("R4 high on level 1", r, 32'h20);
        rd(A_VAL, r);     chk("R3 value after rise", r, 32'h20);

        wr(A_RISE_PD, ~32'h20);
        rd(A_RISE_PD, r); chk("R6 zero bits keep flag", r, 32'h20);
        wr(A_RISE_PD, 32'h20);
        rd(A_RISE_PD, r); chk("R6 one bit clears rise", r, 0);
        wr(A_HI_PD, 32'h20);
        rd(A_HI_PD, r);   chk("R6 high set wins", r, 32'h20);

        // R7: interrupt routing
        @(negedge clk);   chk("R7 irq with no enables", irq, 0);
        wr(A_HI_EN, 32'h20);
        @(negedge clk);   chk("R7 irq from high", irq, 32'h20);
        wr(A_HI_EN, 0);
        wr(A_RISE_EN, 32'h20);
        @(negedge clk);   chk("R7 irq rise enabled, not pending", irq, 0);
        set_ext(5, 1'b1, 1'b0);
        repeat (2) @(posedge clk);
        rd(A_FALL_PD, r); chk("R5 fall on 1->0", r, 32'h20);
        rd(A_RISE_PD, r); chk("R5 no rise on 1->0", r, 0);
        chk("R7 irq fall pending, not enabled", irq, 0);
        wr(A_FALL_EN, 32'h20);
        @(negedge clk);   chk("R7 irq from fall", irq, 32'h20);
        wr(A_FALL_EN, 0);
        wr(A_RISE_EN, 0);

        // R10: contention flag
        wr(A_CONFL, 32'hFFFF_FFFF);
        rd(A_CONFL, r);   chk("R10 contention clear", r, 0);
        wr(A_OEN, 32'h20);
        @(posedge clk);
        rd(A_CONFL, r);   chk("R10 contention set", r, 32'h20);
        wr(A_OEN, 0);
        @(posedge clk);
        rd(A_CONFL, r);   chk("R10 contention sticky", r, 32'h20);
        wr(A_CONFL, 32'h20);
        rd(A_CONFL, r);   chk("R10 contention w1c", r, 0);

        // R11: stored-only registers
        @(negedge clk); snap = pin_out;
        wr(A_DRV, 32'hA5A5_A5A5);
        rd(A_DRV, r);     chk("R11 drive readback", r, 32'hA5A5_A5A5);
        wr(A_ALTEN, 32'hFFFF_FFFF);
        wr(A_ALTSEL, 32'h1234_5678);
        rd(A_ALTEN, r);   chk("R11 alt enable readback", r, 32'hFFFF_FFFF);
        rd(A_ALTSEL, r);  chk("R11 alt select readback", r, 32'h1234_5678);
        chk("R11 pins unaffected", pin_out, snap);

        // R9 R3: unmapped, misaligned, read-only
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, r);     chk("R9 unmapped read zero", r, 0);
        rd(8'h05, r);     chk("R9 misaligned read zero", r, 0);
        wr(8'h0A, 32'hFFFF_FFFF);
        rd(A_OEN, r);     chk("R9 misaligned write ignored", r, 0);
        chk("R9 pins unaffected", pin_out, snap);
        wr(A_VAL, 32'hFFFF_FFFF);
        rd(A_VAL, r);     chk("R3 value reg read-only", r, 0);

        // R12: capture delay and undriven pins
        @(negedge clk);
        pin_driven[7] = 1'b1; pin_in[7] = 1'b1;
        #1 chk("R12 before capture edge", 32'(pin_out[7]), 0);
        @(posedge clk);
        #1 chk("R12 after capture edge", 32'(pin_out[7]), 1);
        wr(A_PULL, 32'h80);
        set_ext(7, 1'b0, 1'b0);
        @(posedge clk);
        #1 chk("R12 undriven uses pull-up", 32'(pin_out[7]), 1);
        set_ext(7, 1'b0, 1'b1);
        @(posedge clk);
        set_ext(7, 1'b0, 1'b0);
        @(posedge clk);
        #1 chk("R12 undriven input ignored", 32'(pin_out[7]), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule